// File: doc/BRIEF.md
# Serial ADC Frame Controller

This block is the host side of a three-wire serial link to a four-channel, 12-bit successive-approximation converter that has an active-low chip select. Every conversion takes exactly one frame. Chip select falls, and that edge is the moment the converter samples its input. Sixteen serial clocks then follow. During those clocks the controller shifts a control word out on the data-in line and captures the 16-bit result from the data-out line. The serial clock is made from the system clock by a fixed half-period divider. An elaboration check refuses any divider setting that would give a serial clock faster than 20 MHz or slower than 10 kHz.

The returned word has a fixed layout:

- two leading zeros,
- a 2-bit channel tag,
- 12 result bits, sent most significant bit first.

The controller checks this framing and presents the tag, the data and an error flag in an output register with a valid/ready handshake. A new frame is launched only when that register is empty and the host has either pulsed a start request or set continuous mode.

Between frames the controller holds chip select high for a minimum quiet time. After reset, and whenever the shutdown input is released, it waits a power-up interval. It then runs one dummy frame, whose only job is to load the channel address, and delivers no result from it.

Top module: `sar_link_ctrl`

## Requirements
- R1: Reset state and power-up wait.
  - During reset, `adc_cs_n` is 1, `adc_sclk` is 1 and `out_valid` is 0.
  - After reset is released, chip select does not fall for at least PWRUP_CYC (= ceil(PWRUP_NS·SYS_MHZ/1000)) clock cycles.
- R2: Frame length and idle clock level.
  - While chip select is low, `adc_sclk` has exactly 16 falling edges.
  - Whenever chip select is high, `adc_sclk` is high.
- R3: Control word on `adc_din`.
  - The word is sent most significant bit first. Each bit is stable at the falling edge that samples it.
  - Bit layout: [15]=1 (write), [14:13]=`cfg_seq`, [12:11]=`cfg_chan`, [10:9]=2'b11 (normal power), [8]=`cfg_range`, [7]=`cfg_twos`, [6:0]=0.
  - The configuration inputs are sampled when chip select falls.
- R4: Result capture from `adc_dout`.
  - The data-out level is captured after each of the 16 falling edges. The first bit is the level present once chip select has fallen.
  - `out_data` is bits [11:0] of the captured word and `out_chan` is bits [13:12].
- R5: Framing error.
  - `out_frame_err` is 1 when bits [15:14] are nonzero, or when the tag in bits [13:12] differs from the channel written in the previous frame.
  - The result is delivered in either case.
- R6: The first frame after reset or after wake-up is a dummy: it never asserts `out_valid`.
- R7: Between the end of one frame and the start of the next, chip select stays high for at least QUIET_CYC (= ceil(QUIET_NS·SYS_MHZ/1000)) cycles.
- R8: After the 16th falling edge, chip select stays low for exactly HALF_DIV cycles before it rises.
- R9: Every serial clock high or low phase inside a frame lasts exactly HALF_DIV cycles, including the first high phase after chip select falls.
- R10: Output handshake.
  - While `out_valid` is 1 and `out_ready` is 0, the output fields hold steady and no non-dummy frame starts.
  - `out_valid` drops in the cycle after a handshake.
- R11: Start control.
  - One `start` pulse launches exactly one frame.
  - With `cfg_continuous` set, frames repeat back to back.
  - With neither set, no frame starts.
- R12: Shutdown and wake-up.
  - While `cfg_shutdown` is 1, no frame starts.
  - After it falls, chip select stays high for at least PWRUP_CYC cycles, then a dummy frame runs, and normal frames follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request for one conversion |
| cfg_continuous | input | 1 | Launch frames back to back whenever the output register is empty |
| cfg_shutdown | input | 1 | Hold the link idle; releasing it triggers power-up wait and a dummy frame |
| cfg_chan | input | 2 | Channel address written in the control word |
| cfg_seq | input | 2 | Sequencer mode bits written in the control word |
| cfg_range | input | 1 | Input range bit written in the control word |
| cfg_twos | input | 1 | Output coding bit written in the control word |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_cs_n | output | 1 | Active-low chip select; its falling edge samples the input |
| adc_din | output | 1 | Control word to converter |
| adc_dout | input | 1 | Result word from converter |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer accepts the result |
| out_chan | output | 2 | Channel tag returned with the result |
| out_data | output | 12 | Conversion result |
| out_frame_err | output | 1 | Leading bits nonzero or channel tag mismatch |

## Verification
The hardest situation to reach from the ports is a channel tag that disagrees with the address written one frame earlier. The bench's converter model returns, for each frame, a tag derived from the channel the bench itself addressed in the previous frame. Table entries can flip one tag bit or corrupt the leading zeros, and the bench records the address carried by the dummy frame so that the first real comparison has a reference. Wake-up is reached by holding shutdown across several idle intervals and then releasing it with a start already pending. The bench then confirms that the dummy frame swallows its result and that the pending request is served afterwards.

// File: rtl/sar_link_pkg.sv
package sar_link_pkg;
  localparam int FRAME_BITS = 16;
  localparam int DATA_BITS  = 12;

  typedef enum logic [1:0] {ST_WAKE, ST_IDLE, ST_FRAME, ST_QUIET} link_state_e;

  // control word: write flag, sequencer, channel, power=normal, range, coding
  function automatic logic [FRAME_BITS-1:0] build_ctl(input logic [1:0] chan,
                                                      input logic [1:0] seq,
                                                      input logic       rng,
                                                      input logic       twos);
    build_ctl = {1'b1, seq, chan, 2'b11, rng, twos, 7'd0};
  endfunction

  // result word must start with two zeros and carry the expected tag
  function automatic logic frame_bad(input logic [FRAME_BITS-1:0] word,
                                     input logic [1:0]            exp_chan);
    frame_bad = (word[15:14] != 2'b00) || (word[13:12] != exp_chan);
  endfunction
endpackage

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
  parameter int HALF_DIV = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic fall_ev,
  output logic rise_ev
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          edge_due;

  assign edge_due = run && (cnt == LAST);
  assign fall_ev  = edge_due && sclk;
  assign rise_ev  = edge_due && !sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b1;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b1;
    end else if (edge_due) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // each toggle inside a running frame ends a full half period
  assert_half_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (sclk != $past(sclk))) |-> ($past(cnt) == LAST));
endmodule

// File: rtl/sar_wait_timer.sv
module sar_wait_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= W'(RST_VAL);
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sar_link_ctrl.sv
module sar_link_ctrl
  import sar_link_pkg::*;
#(
  parameter int SYS_MHZ  = 250,
  parameter int HALF_DIV = 7,
  parameter int QUIET_NS = 50,
  parameter int PWRUP_NS = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        cfg_continuous,
  input  logic        cfg_shutdown,
  input  logic [1:0]  cfg_chan,
  input  logic [1:0]  cfg_seq,
  input  logic        cfg_range,
  input  logic        cfg_twos,
  output logic        adc_sclk,
  output logic        adc_cs_n,
  output logic        adc_din,
  input  logic        adc_dout,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [1:0]  out_chan,
  output logic [11:0] out_data,
  output logic        out_frame_err
);
  localparam int QUIET_CYC = (QUIET_NS * SYS_MHZ + 999) / 1000;
  localparam int PWRUP_CYC = (PWRUP_NS * SYS_MHZ + 999) / 1000;
  localparam int TMAX      = (PWRUP_CYC > QUIET_CYC) ? PWRUP_CYC : QUIET_CYC;
  localparam int TW        = $clog2(TMAX + 1);
  localparam int BW        = $clog2(FRAME_BITS + 1);

  // serial clock = SYS_MHZ / (2*HALF_DIV) MHz must lie in 10 kHz .. 20 MHz
  generate
    if (SYS_MHZ > 40 * HALF_DIV) begin : g_sclk_too_fast
      $error("serial clock divider gives more than 20 MHz");
    end
    if (HALF_DIV > 50 * SYS_MHZ) begin : g_sclk_too_slow
      $error("serial clock divider gives less than 10 kHz");
    end
  endgenerate

  link_state_e           state;
  logic                  cs_n_q;
  logic [FRAME_BITS-1:0] tx_sh;
  logic [FRAME_BITS-1:0] rx_sh;
  logic [BW-1:0]         bitcnt;
  logic                  dummy_q;
  logic                  asleep;
  logic                  start_pend;
  logic [1:0]            cur_chan;
  logic [1:0]            prev_chan;

  // named internal events
  logic          run;
  logic          fall_ev;
  logic          rise_ev;
  logic          frame_end;
  logic          launch;
  logic          wake_go;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_done;

  assign run       = (state == ST_FRAME);
  assign frame_end = rise_ev && (bitcnt == BW'(FRAME_BITS));
  assign wake_go   = (state == ST_IDLE) && !cfg_shutdown && asleep;
  assign launch    = (state == ST_IDLE) && !cfg_shutdown && !asleep &&
                     (dummy_q || ((start_pend || cfg_continuous) && !out_valid));
  assign tmr_load  = wake_go || frame_end;
  assign tmr_val   = wake_go ? TW'(PWRUP_CYC) : TW'(QUIET_CYC);

  sar_sclk_gen #(.HALF_DIV(HALF_DIV)) i_sclk (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sclk(adc_sclk), .fall_ev(fall_ev), .rise_ev(rise_ev)
  );

  sar_wait_timer #(.W(TW), .RST_VAL(PWRUP_CYC)) i_wait (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_WAKE;
      cs_n_q     <= 1'b1;
      tx_sh      <= '0;
      rx_sh      <= '0;
      bitcnt     <= '0;
      dummy_q    <= 1'b1;
      asleep     <= 1'b0;
      start_pend <= 1'b0;
      cur_chan   <= '0;
      prev_chan  <= '0;
    end else begin
      start_pend <= (start_pend && !(launch && !dummy_q)) || start;
      case (state)
        ST_WAKE: if (tmr_done) state <= ST_IDLE;
        ST_IDLE: begin
          if (cfg_shutdown) begin
            asleep <= 1'b1;
          end else if (asleep) begin
            asleep  <= 1'b0;
            dummy_q <= 1'b1;
            state   <= ST_WAKE;
          end else if (launch) begin
            cs_n_q   <= 1'b0;
            tx_sh    <= build_ctl(cfg_chan, cfg_seq, cfg_range, cfg_twos);
            cur_chan <= cfg_chan;
            bitcnt   <= '0;
            state    <= ST_FRAME;
          end
        end
        ST_FRAME: begin
          if (fall_ev) begin
            rx_sh  <= {rx_sh[FRAME_BITS-2:0], adc_dout};
            bitcnt <= bitcnt + BW'(1);
          end
          if (frame_end) begin
            cs_n_q    <= 1'b1;
            state     <= ST_QUIET;
            prev_chan <= cur_chan;
            dummy_q   <= 1'b0;
          end else if (rise_ev) begin
            tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
          end
        end
        ST_QUIET: if (tmr_done) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_chan      <= '0;
      out_data      <= '0;
      out_frame_err <= 1'b0;
    end else if (frame_end && !dummy_q) begin
      out_valid     <= 1'b1;
      out_data      <= rx_sh[DATA_BITS-1:0];
      out_chan      <= rx_sh[13:12];
      out_frame_err <= frame_bad(rx_sh, prev_chan);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign adc_cs_n = cs_n_q;
  assign adc_din  = tx_sh[FRAME_BITS-1];

  assert_sclk_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> adc_sclk);

  assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |-> ($past(bitcnt) == BW'(FRAME_BITS)));

  assert_quiet_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> $past(tmr_done));

  assert_no_result_from_dummy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !$past(dummy_q));

  assert_launch_only_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(adc_cs_n) && !dummy_q) |-> !$past(out_valid));

  assert_hold_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_chan) && $stable(out_frame_err)));
endmodule

// File: tb/test_sar_link_ctrl.sv
module test_sar_link_ctrl;
  localparam int HALF      = 7;
  localparam int QUIET_CYC = 13;   // ceil(50 ns * 250 MHz)
  localparam int PWRUP_CYC = 250;  // 1 us * 250 MHz
  localparam int WATCHDOG  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cfg_continuous = 1'b0;
  logic        cfg_shutdown = 1'b0;
  logic [1:0]  cfg_chan = 2'd0;
  logic [1:0]  cfg_seq = 2'd0;
  logic        cfg_range = 1'b0;
  logic        cfg_twos = 1'b0;
  logic        out_ready = 1'b1;
  logic        adc_sclk, adc_cs_n, adc_din;
  logic        adc_dout = 1'b0;
  logic        out_valid, out_frame_err;
  logic [1:0]  out_chan;
  logic [11:0] out_data;

  always #2 clk = ~clk;  // 250 MHz

  sar_link_ctrl #(.SYS_MHZ(250), .HALF_DIV(HALF), .QUIET_NS(50), .PWRUP_NS(1000))
    i_sar_link_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_continuous(cfg_continuous),
      .cfg_shutdown(cfg_shutdown), .cfg_chan(cfg_chan), .cfg_seq(cfg_seq),
      .cfg_range(cfg_range), .cfg_twos(cfg_twos), .adc_sclk(adc_sclk),
      .adc_cs_n(adc_cs_n), .adc_din(adc_din), .adc_dout(adc_dout),
      .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
      .out_data(out_data), .out_frame_err(out_frame_err));

  // converter model: first bit on chip select fall, next bits after each sclk fall
  logic [15:0] resp_word = 16'h0000;
  logic [15:0] rx_din = 16'h0000;
  int          mbit = 0;
  always @(negedge adc_cs_n or negedge adc_sclk) begin
    if (adc_sclk) begin
      mbit     = 0;
      rx_din   = 16'h0000;
      adc_dout = resp_word[15];
    end else if (!adc_cs_n) begin
      rx_din   = {rx_din[14:0], adc_din};
      mbit     = mbit + 1;
      adc_dout = (mbit < 16) ? resp_word[4'(15 - mbit)] : 1'b0;
    end
  end

  // timing monitor
  int   mchecks = 0, mfails = 0, frames = 0, valid_rises = 0;
  int   falls = 0, hlen = 0, qlen = 1000;
  logic p_cs = 1'b1, p_sclk = 1'b1, p_valid = 1'b0;

  task automatic mcheck(input bit ok, input string req, input int act, input int exp);
    mchecks++;
    if (!ok) begin
      mfails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_cs && !adc_cs_n) begin
        mcheck(qlen >= QUIET_CYC, "R7 quiet time", qlen, QUIET_CYC);
        mcheck(!p_valid, "R10 frame started with full output", int'(p_valid), 0);
        frames++;
        falls = 0;
        hlen  = 1;
      end else if (!p_cs && adc_cs_n) begin
        mcheck(falls == 16, "R2 falling edges per frame", falls, 16);
        mcheck(hlen == HALF, "R8 tail after last fall", hlen, HALF);
        qlen = 1;
      end else if (!adc_cs_n) begin
        if (adc_sclk != p_sclk) begin
          mcheck(hlen == HALF, "R9 half period", hlen, HALF);
          hlen = 1;
          if (!adc_sclk) falls++;
        end else begin
          hlen++;
        end
      end else begin
        qlen++;
      end
      if (!p_valid && out_valid) valid_rises++;
      p_cs    = adc_cs_n;
      p_sclk  = adc_sclk;
      p_valid = out_valid;
    end
  end

  // stimulus/expect table: {chan, seq, range, twos, lead, tag_ok, data}
  localparam logic [20:0] VECS [0:7] = '{
    {2'd1, 2'd0, 1'b0, 1'b0, 2'b00, 1'b1, 12'h000},
    {2'd2, 2'd1, 1'b1, 1'b0, 2'b00, 1'b1, 12'hFFF},
    {2'd3, 2'd2, 1'b0, 1'b1, 2'b00, 1'b1, 12'hA5A},
    {2'd0, 2'd3, 1'b1, 1'b1, 2'b01, 1'b1, 12'h5A5},
    {2'd1, 2'd0, 1'b0, 1'b0, 2'b10, 1'b1, 12'h800},
    {2'd2, 2'd0, 1'b1, 1'b1, 2'b00, 1'b0, 12'h001},
    {2'd0, 2'd2, 1'b0, 1'b0, 2'b11, 1'b0, 12'h7FE},
    {2'd3, 2'd1, 1'b1, 1'b0, 2'b00, 1'b1, 12'h123}
  };

  int       nchecks = 0, nfails = 0;
  logic [1:0] last_chan = 2'd0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valid();
    while (!out_valid) @(negedge clk);
  endtask

  // one conversion: configure, answer with a built word, check everything
  task automatic one_conv(input logic [20:0] v);
    logic [1:0]  ch, tag;
    logic [15:0] exp_ctl;
    int          fb;
    ch        = v[20:19];
    tag       = v[12] ? last_chan : (last_chan ^ 2'b10);
    resp_word = {v[14:13], tag, v[11:0]};
    cfg_chan  = ch;
    cfg_seq   = v[18:17];
    cfg_range = v[16];
    cfg_twos  = v[15];
    exp_ctl   = {1'b1, v[18:17], ch, 2'b11, v[16], v[15], 7'd0};
    fb        = frames;
    pulse_start();
    wait_valid();
    check(out_data == v[11:0], "R4 result data", int'(out_data), int'(v[11:0]));
    check(out_chan == tag, "R4 channel tag", int'(out_chan), int'(tag));
    check(out_frame_err == ((v[14:13] != 2'b00) || !v[12]), "R5 framing error",
          int'(out_frame_err), int'((v[14:13] != 2'b00) || !v[12]));
    check(rx_din == exp_ctl, "R3 control word", int'(rx_din), int'(exp_ctl));
    check(frames == fb + 1, "R11 one frame per start", frames, fb + 1);
    last_chan = ch;
    @(negedge clk);
  endtask

  task automatic run_all();
    int t, f0, v0;
    logic [11:0] held;
    // reset state
    repeat (5) @(negedge clk);
    check(adc_cs_n == 1'b1, "R1 reset cs_n", int'(adc_cs_n), 1);
    check(adc_sclk == 1'b1, "R1 reset sclk", int'(adc_sclk), 1);
    check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    t = 0;
    while (adc_cs_n) begin @(negedge clk); t++; end
    check(t >= PWRUP_CYC, "R1 power-up wait", t, PWRUP_CYC);
    while (!adc_cs_n) @(negedge clk);
    repeat (40) @(negedge clk);
    check(valid_rises == 0, "R6 dummy frame after reset", valid_rises, 0);

    // table walk
    for (int i = 0; i < 8; i++) one_conv(VECS[i]);

    // output held while consumer stalls
    out_ready = 1'b0;
    one_conv({2'd2, 2'd0, 1'b0, 1'b1, 2'b00, 1'b1, 12'h9C3});
    held = out_data;
    cfg_continuous = 1'b1;
    f0 = frames;
    repeat (300) @(negedge clk);
    check(out_valid == 1'b1, "R10 valid held", int'(out_valid), 1);
    check(out_data == held, "R10 data held", int'(out_data), int'(held));
    check(frames == f0, "R10 no frame while full", frames, f0);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 valid drops after handshake", int'(out_valid), 0);

    // continuous mode repeats frames
    resp_word = {2'b00, cfg_chan, 12'h111};
    f0 = frames;
    repeat (700) @(negedge clk);
    check(frames - f0 >= 2, "R11 continuous frames", frames - f0, 2);
    cfg_continuous = 1'b0;
    while (!adc_cs_n) @(negedge clk);
    repeat (5) @(negedge clk);
    f0 = frames;
    repeat (800) @(negedge clk);
    check(frames == f0, "R11 no request no frame", frames, f0);

    // shutdown, then wake with a dummy frame
    cfg_shutdown = 1'b1;
    pulse_start();
    repeat (600) @(negedge clk);
    check(frames == f0, "R12 no frame in shutdown", frames, f0);
    cfg_chan = 2'd1;
    v0 = valid_rises;
    cfg_shutdown = 1'b0;
    t = 0;
    while (adc_cs_n) begin @(negedge clk); t++; end
    check(t >= PWRUP_CYC, "R12 power-up wait after wake", t, PWRUP_CYC);
    while (!adc_cs_n) @(negedge clk);
    last_chan = 2'd1;
    repeat (3) @(negedge clk);
    check(valid_rises == v0, "R6 dummy frame after wake", valid_rises, v0);
    // pending start from shutdown is served after the dummy
    resp_word = {2'b00, 2'd1, 12'h3C3};
    wait_valid();
    check(out_data == 12'h3C3, "R12 pending request served", int'(out_data), 'h3C3);
    check(out_frame_err == 1'b0, "R5 tag follows dummy address", int'(out_frame_err), 0);
    @(negedge clk);
    one_conv({2'd3, 2'd3, 1'b0, 1'b0, 2'b00, 1'b0, 12'h0F0});
  endtask

  initial begin
    bit wd = 1'b0;
    fork
      run_all();
      begin
        repeat (WATCHDOG) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      nchecks++;
      nfails++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nchecks + mchecks, nfails + mfails);
    $finish;
  end
endmodule